// File: doc/BRIEF.md
# Multi-Channel Trigger Combiner

This block turns a vector of per-channel self-trigger bits into board-level trigger signals. It holds two identical combiner paths, A and B, that work independently and are configured separately. Each path first drops the channels its enable mask clears. It can then join neighbouring channel pairs by OR or AND. Next it applies one main rule: OR of all enabled channels, AND of all enabled channels, or a majority count against a programmable level. Last, a shaper passes the result through unchanged or stretches it into a gate of programmable length, and an optional inversion is applied at the very end.

A second-level stage takes the shaped A and B signals before inversion and provides both their AND and their OR. The majority count uses a two-level registered adder tree. Every main rule shares one pipeline, so all outputs stay aligned in time whatever the configuration.

Top module: `trig_combiner`

## Requirements
- R1: A channel whose bit is 0 in a path's 64-bit mask (bit i belongs to channel i) has no effect on that path's result.
- R2: Pair setting 0 (or 3) passes the masked channels through unchanged. Pair setting 1 ORs channels 2k and 2k+1 and drives both positions of the pair with the result.
- R3: Pair setting 2 ANDs channels 2k and 2k+1 and drives both positions of the pair with the result.
- R4: Main setting 0 makes the path active when any position of the paired vector is 1.
- R5: Main setting 1 is active when every mask-enabled position of the paired vector is 1. An all-zero mask forces it low.
- R6: Main setting 2 is active in any cycle where the number of 1 positions in the paired vector (a joined pair counts as two) is at least the level. Main setting 3 drives the path low.
- R7: Latency is fixed for every setting: the input present at rising edge n shows at the outputs right after edge n+3.
- R8: A gate width of 0 gives linear output: the shaped signal follows the main result with the fixed latency.
- R9: Non-retriggerable gate (width W>0, retrig 0): a rise of the main result while the gate is closed opens it for exactly W cycles. A further rise while it is open is ignored, and a steady high level does not reopen it.
- R10: Retriggerable gate (retrig 1): every cycle with the main result high reloads the gate to W cycles, so it closes W cycles after the last active cycle.
- R11: With invert set, the path output is the complement of the shaped signal.
- R12: trig_and is the AND and trig_or the OR of the shaped A and B signals, taken before inversion.
- R13: During and right after reset, the shaped signals are 0. Each path output then equals its invert setting, and trig_and and trig_or are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_trig | input | NCH | Per-channel self-trigger bits |
| a_mask | input | NCH | Path A channel enables |
| a_pair_mode | input | 2 | Path A pair logic: 0 none, 1 OR, 2 AND, 3 none |
| a_main_mode | input | 2 | Path A main logic: 0 OR, 1 AND, 2 majority, 3 off |
| a_level | input | CW | Path A majority level |
| a_gate_width | input | GW | Path A gate length in cycles, 0 = linear |
| a_retrig | input | 1 | Path A retriggerable gate |
| a_invert | input | 1 | Path A output inversion |
| b_mask | input | NCH | Path B channel enables |
| b_pair_mode | input | 2 | Path B pair logic |
| b_main_mode | input | 2 | Path B main logic |
| b_level | input | CW | Path B majority level |
| b_gate_width | input | GW | Path B gate length in cycles |
| b_retrig | input | 1 | Path B retriggerable gate |
| b_invert | input | 1 | Path B output inversion |
| trig_a | output | 1 | Shaped path A trigger |
| trig_b | output | 1 | Shaped path B trigger |
| trig_and | output | 1 | Shaped A AND shaped B |
| trig_or | output | 1 | Shaped A OR shaped B |

## Verification
In a non-retriggerable gate, a new rising edge of the main result can land in the same cycle as the gate's final open cycle or its closing. The case is provoked by pulse trains whose spacing is equal to the gate width and one longer than it. The expected result is that a rise arriving while the counter still holds 1 is dropped, and a rise in the cycle after closing opens a fresh gate. A reference model in the scoreboard follows the same rules cycle by cycle, and every output is compared with it at every cycle. Config changes go through reset, so no config ever mixes with data from an earlier config.

// File: rtl/trig_combiner.sv
`timescale 1ns/1ps
module trig_combiner #(
  parameter int NCH = 64,
  parameter int GRP = 8,
  parameter int GW  = 8,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_trig,
  input  logic [NCH-1:0] a_mask,
  input  logic [1:0]     a_pair_mode,
  input  logic [1:0]     a_main_mode,
  input  logic [CW-1:0]  a_level,
  input  logic [GW-1:0]  a_gate_width,
  input  logic           a_retrig,
  input  logic           a_invert,
  input  logic [NCH-1:0] b_mask,
  input  logic [1:0]     b_pair_mode,
  input  logic [1:0]     b_main_mode,
  input  logic [CW-1:0]  b_level,
  input  logic [GW-1:0]  b_gate_width,
  input  logic           b_retrig,
  input  logic           b_invert,
  output logic           trig_a,
  output logic           trig_b,
  output logic           trig_and,
  output logic           trig_or
);
  localparam int NPAIR = NCH / 2;
  localparam int NG    = NCH / GRP;
  localparam int PW    = $clog2(GRP + 1);
  localparam logic [NCH-1:0] EVEN = {NPAIR{2'b01}};

  logic [1:0][NCH-1:0] mask_i;
  logic [1:0][1:0]     pair_i, mode_i;
  logic [1:0][CW-1:0]  level_i;
  logic [1:0][GW-1:0]  width_i;
  logic [1:0]          retrig_i, inv_i, shaped;

  assign mask_i   = {b_mask, a_mask};
  assign pair_i   = {b_pair_mode, a_pair_mode};
  assign mode_i   = {b_main_mode, a_main_mode};
  assign level_i  = {b_level, a_level};
  assign width_i  = {b_gate_width, a_gate_width};
  assign retrig_i = {b_retrig, a_retrig};
  assign inv_i    = {b_invert, a_invert};

  for (genvar gi = 0; gi < 2; gi++) begin : g_path
    logic [NCH-1:0] masked, paired, s1_vec, s1_mask;
    logic [NG-1:0][PW-1:0] psum;
    logic [CW-1:0] total;
    logic or2, and2, main, main_d, lin, trig;
    logic [GW-1:0] cnt;

    assign masked = chan_trig & mask_i[gi];

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      logic pr;
      assign pr = (pair_i[gi] == 2'd1) ? (masked[2*k] | masked[2*k+1])
                                       : (masked[2*k] & masked[2*k+1]);
      assign paired[2*k+1:2*k] = (pair_i[gi] == 2'd1 || pair_i[gi] == 2'd2)
                                 ? {2{pr}} : masked[2*k+1:2*k];
    end

    always_comb begin
      total = '0;
      for (int g = 0; g < NG; g++) total = total + CW'(psum[g]);
    end

    assign trig = retrig_i[gi] ? main : (main & ~main_d);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_vec <= '0; s1_mask <= '0; psum <= '0; or2 <= 1'b0; and2 <= 1'b0;
        main <= 1'b0; main_d <= 1'b0; lin <= 1'b0; cnt <= '0;
      end else begin
        s1_vec  <= paired;
        s1_mask <= mask_i[gi];
        for (int g = 0; g < NG; g++)
          psum[g] <= PW'($countones(s1_vec[g*GRP +: GRP]));
        or2  <= |s1_vec;
        and2 <= (|s1_mask) && (&(s1_vec | ~s1_mask));
        case (mode_i[gi])
          2'd0:    main <= or2;
          2'd1:    main <= and2;
          2'd2:    main <= (total >= level_i[gi]);
          default: main <= 1'b0;
        endcase
        main_d <= main;
        lin    <= main;
        if (trig && (cnt == '0 || retrig_i[gi])) cnt <= width_i[gi];
        else if (cnt != '0)                      cnt <= cnt - GW'(1);
      end
    end

    assign shaped[gi] = (width_i[gi] == '0) ? lin : (cnt != '0);

    // R2
    pair_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pair_i[gi]) == 2'd1 || $past(pair_i[gi]) == 2'd2)
      |-> ((s1_vec & EVEN) == ((s1_vec >> 1) & EVEN)));
    // R5
    zero_mask_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_i[gi]) == 2'd1 && $past(mask_i[gi] == '0, 3)) |-> !main);
    // R9
    gate_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!retrig_i[gi] && cnt != '0) |=> (cnt == $past(cnt) - GW'(1)));
    // R10
    retrig_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retrig_i[gi] && main) |=> (cnt == $past(width_i[gi])));
  end

  assign trig_a   = shaped[0] ^ inv_i[0];
  assign trig_b   = shaped[1] ^ inv_i[1];
  assign trig_and = shaped[0] & shaped[1];
  assign trig_or  = shaped[0] | shaped[1];
endmodule

// File: tb/trig_combiner_test.sv
`timescale 1ns/1ps
module trig_combiner_test;
  localparam int NCH = 64;
  localparam int GW  = 8;
  localparam int CW  = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] chan_trig = '0;
  logic [NCH-1:0] a_mask = '0, b_mask = '0;
  logic [1:0] a_pair = '0, a_mode = '0, b_pair = '0, b_mode = '0;
  logic [CW-1:0] a_level = '0, b_level = '0;
  logic [GW-1:0] a_width = '0, b_width = '0;
  logic a_retrig = 0, a_inv = 0, b_retrig = 0, b_inv = 0;
  logic trig_a, trig_b, trig_and, trig_or;

  int checks = 0, fails = 0;
  string cur_req = "R13";
  bit running = 0;
  logic [1:0] q[$];
  logic [2:0] dla, dlb;
  logic pa, pb;
  int ca, cb;

  always #2.5 clk = ~clk;

  trig_combiner uut (
    .clk(clk), .rst_n(rst_n), .chan_trig(chan_trig),
    .a_mask(a_mask), .a_pair_mode(a_pair), .a_main_mode(a_mode), .a_level(a_level),
    .a_gate_width(a_width), .a_retrig(a_retrig), .a_invert(a_inv),
    .b_mask(b_mask), .b_pair_mode(b_pair), .b_main_mode(b_mode), .b_level(b_level),
    .b_gate_width(b_width), .b_retrig(b_retrig), .b_invert(b_inv),
    .trig_a(trig_a), .trig_b(trig_b), .trig_and(trig_and), .trig_or(trig_or));

  function automatic logic ref_main(input logic [NCH-1:0] v, input logic [NCH-1:0] m,
                                    input logic [1:0] pr, input logic [1:0] md,
                                    input logic [CW-1:0] lv);
    logic [NCH-1:0] x, p;
    x = v & m;
    p = x;
    for (int k = 0; k < NCH/2; k++) begin
      if (pr == 2'd1) p[2*k +: 2] = {2{x[2*k] | x[2*k+1]}};
      if (pr == 2'd2) p[2*k +: 2] = {2{x[2*k] & x[2*k+1]}};
    end
    case (md)
      2'd0: return |p;
      2'd1: return (m != '0) && (&(p | ~m));
      2'd2: return $countones(p) >= int'(lv);
      default: return 1'b0;
    endcase
  endfunction

  function automatic void ref_shape(input logic m, input logic [GW-1:0] w, input logic rt,
                                    inout logic prev, inout int c, output logic s);
    logic t;
    t = rt ? m : (m & ~prev);
    if (t && (c == 0 || rt)) c = int'(w);
    else if (c != 0) c = c - 1;
    prev = m;
    s = (w == '0) ? m : (c != 0);
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {a,b,and,or} actual=%b expected=%b at %0t", cur_req, act, exp, $time);
    end
  endtask

  always begin
    logic [1:0] it;
    logic sa, sb;
    @(posedge clk);
    #1;
    if (running && q.size() > 0) begin
      it = q.pop_front();
      ref_shape(dla[2], a_width, a_retrig, pa, ca, sa);
      ref_shape(dlb[2], b_width, b_retrig, pb, cb, sb);
      dla = {dla[1:0], it[1]};
      dlb = {dlb[1:0], it[0]};
      check({trig_a, trig_b, trig_and, trig_or}, {sa ^ a_inv, sb ^ b_inv, sa & sb, sa | sb});
    end
  end

  task automatic drive(input logic [NCH-1:0] v);
    chan_trig = v;
    q.push_back({ref_main(v, a_mask, a_pair, a_mode, a_level),
                 ref_main(v, b_mask, b_pair, b_mode, b_level)});
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive('0);
  endtask

  task automatic rnd(input int n);
    for (int i = 0; i < n; i++)
      drive({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
  endtask

  task automatic configure(input string tag);
    logic za, zb;
    running = 0;
    rst_n = 1'b0;
    chan_trig = '0;
    q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    za = ref_main('0, a_mask, a_pair, a_mode, a_level);
    zb = ref_main('0, b_mask, b_pair, b_mode, b_level);
    dla = {1'b0, za, za};
    dlb = {1'b0, zb, zb};
    pa = 0; pb = 0; ca = 0; cb = 0;
    cur_req = "R13";
    check({trig_a, trig_b, trig_and, trig_or}, {a_inv, b_inv, 1'b0, 1'b0});
    cur_req = tag;
    running = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 R4 R8 R12: mask, OR rule, linear output, second level
    a_mask = {32'h0, 32'hFFFF_FFFF}; b_mask = '1;
    configure("R1 R4 R8 R12");
    drive(64'h1 << 40); idle(4);
    drive(64'h1 << 5);  idle(4);
    drive((64'h1 << 40) | (64'h1 << 63)); idle(4);
    rnd(20); idle(4);

    // R2 R6: pair OR counts twice under majority, no pairing counts once
    a_pair = 2'd1; a_mode = 2'd2; a_level = 7'd2;
    b_pair = 2'd0; b_mode = 2'd2; b_level = 7'd2;
    configure("R2 R6");
    drive(64'h1 << 6); idle(4);
    drive((64'h1 << 6) | (64'h1 << 20)); idle(4);
    rnd(20); idle(4);

    // R3: pair AND needs both members of the same pair
    a_pair = 2'd2; a_mode = 2'd0;
    b_pair = 2'd2; b_mode = 2'd2; b_level = 7'd4;
    configure("R3");
    drive(64'h40); idle(4);
    drive(64'hC0); idle(4);
    drive(64'h180); idle(4);
    drive(64'h30_00C0); idle(4);
    rnd(20); idle(4);

    // R5: AND over enabled channels only, empty mask stays low
    a_pair = 2'd0; a_mode = 2'd1; a_mask = 64'hF0;
    b_pair = 2'd0; b_mode = 2'd1; b_mask = '0;
    configure("R5");
    drive(64'hF0); idle(4);
    drive(64'h70); idle(4);
    drive('1); idle(4);
    rnd(10); idle(4);

    // R6: majority level 3 and level 0, plus disabled rule 3
    a_mask = '1; a_mode = 2'd2; a_level = 7'd3;
    b_mask = '1; b_mode = 2'd2; b_level = 7'd0;
    configure("R6");
    drive(64'h11); drive(64'h111); drive(64'h1F); idle(4);
    rnd(20); idle(4);
    b_mode = 2'd3;
    configure("R6 off");
    drive('1); idle(4);

    // R9 R10 R11 R7: gates, inversion, fixed latency
    a_mode = 2'd0; a_width = 8'd4; a_retrig = 0;
    b_mode = 2'd0; b_width = 8'd3; b_retrig = 1; b_inv = 1;
    configure("R9 R10 R11 R7");
    drive(64'h1); idle(8);
    for (int i = 0; i < 10; i++) drive(64'h2);
    idle(8);
    for (int i = 0; i < 6; i++) begin drive(64'h4); idle(1); end
    idle(8);
    for (int i = 0; i < 4; i++) begin drive(64'h8); idle(3); end
    idle(8);
    for (int i = 0; i < 4; i++) begin drive(64'h8); idle(4); end
    idle(8);
    rnd(30); idle(8);

    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule